// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block performs the privileged-state bookkeeping a processor core needs at the moment it takes an exception or an interrupt. The pipeline hands it a cause (a 6-bit main code plus a 9-bit subcode), the PC of the trapping instruction, the raw instruction word and a flag saying that a translation-refill miss is being serviced. On a single strobe it updates the current mode, the saved-mode copies, the cause status, the return addresses and the fault-capture registers, all in one clock edge. One cycle later it presents a redirect PC with a one-cycle valid pulse.

There are three entry paths. On the normal path the cause is recorded and the current mode is saved into the previous-mode copy. On the refill path the mode is saved into a separate refill copy, and the core is forced into direct addressing. On the debug path only the debug registers change. A debug breakpoint always takes the debug path. An interrupt takes it as well when the debug-mode flag is already set, so it is not vectored. Bus errors on a fetch or on a data access are turned into the address-error cause. The interrupt number, the vector spacing and the entry bases come from outside the block. A separate port lets the core restore the current mode outside of a trap.

The controller has two states. In RUN the core executes normally. In DEBUG the debug-mode flag is set. There are two transitions: ENTER_DEBUG, from RUN to DEBUG when a debug-path entry is accepted, and HOLD_DEBUG, which keeps DEBUG until reset. Reset always returns the controller to RUN.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset: privilege level 0, interrupt enable 0, direct-address bit 1, paging bit 0, debug-mode flag 0, status code and subcode 0, redirect PC 0x1C000000, redirect valid 0 and error 0.
- R2: An accepted normal-path entry does the following in the same edge. It writes the effective code and subcode into the status fields, copies the current level and interrupt enable into the previous-mode fields and stores the PC into the return address. It then pulses redirect valid for exactly one cycle after the strobe.
- R3: Every accepted non-debug entry sets the privilege level to 0 and clears the interrupt enable.
- R4: A non-interrupt normal entry redirects to base + (code << (spacing+2)). A spacing of 0 redirects to the base itself.
- R5: An interrupt (code 0) outside debug mode redirects to base + ((64 + interrupt index) << (spacing+2)). A spacing of 0 redirects to the base.
- R6: Codes 11 to 18 copy the PC into the bad-address register. All other codes leave that register unchanged.
- R7: The instruction word is captured into the bad-instruction register for every accepted non-debug entry except code 0, code 3 and code 8 with subcode 0.
- R8: With the refill flag set, a non-debug entry saves the level and interrupt enable into the refill saved-mode fields and stores PC[31:2] into the refill return field. It forces direct addressing on and paging off. The status and the return address are left alone, and a non-interrupt cause redirects to the refill entry.
- R9: Code 26 (debug breakpoint) does the following. It sets the debug-cause bit, writes debug code 0xC, stores the PC as the debug return, sets the debug-mode flag and redirects to base + 0x480. The current mode, the status and the return address are left unchanged.
- R10: Code 0 while the debug-mode flag is set does the following. It sets the debug-interrupt bit, stores the PC as the debug return and redirects to base + 0x480. The status is left unchanged.
- R11: When no trap is strobed, a bus error raises code 8. The subcode is 0 for an instruction fetch and 1 for a data access.
- R12: An unsupported cause raises the error output one cycle after the strobe. Supported codes are 0 to 8, 10 to 18 and 26, and code 8 is supported only with subcode 0 or 1. An unsupported cause produces no redirect and changes no state.
- R13: A mode write loads level, interrupt enable, direct-address and paging bits only in a cycle with no trap or bus error. When both arrive together, the trap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap strobe |
| trap_code | input | 6 | Main cause code |
| trap_sub | input | 9 | Cause subcode |
| trap_pc | input | PC_W | PC of trapping instruction |
| trap_insn | input | INSN_W | Trapping instruction word |
| refill_active | input | 1 | Refill miss being serviced |
| irq_index | input | IRQ_W | Selected interrupt number |
| buserr_valid | input | 1 | Bus error strobe |
| buserr_fetch | input | 1 | Bus error was an instruction fetch |
| entry_base | input | PC_W | Exception entry base |
| refill_entry | input | PC_W | Refill entry address |
| vec_spacing | input | VS_W | Vector spacing exponent |
| mode_wr | input | 1 | Current-mode write strobe |
| mode_wr_plv | input | 2 | Level to write |
| mode_wr_ie | input | 1 | Interrupt enable to write |
| mode_wr_da | input | 1 | Direct-address bit to write |
| mode_wr_pg | input | 1 | Paging bit to write |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | PC_W | Redirect target |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Current interrupt enable |
| cur_da | output | 1 | Direct-address bit |
| cur_pg | output | 1 | Paging bit |
| prv_plv | output | 2 | Saved level (normal path) |
| prv_ie | output | 1 | Saved interrupt enable (normal path) |
| est_code | output | 6 | Status main code |
| est_sub | output | 9 | Status subcode |
| ret_addr | output | PC_W | Normal return address |
| bad_addr | output | PC_W | Bad-address capture |
| bad_insn | output | INSN_W | Bad-instruction capture |
| dbg_mode | output | 1 | Debug-mode flag |
| dbg_cause | output | 1 | Debug breakpoint cause bit |
| dbg_int | output | 1 | Debug interrupt bit |
| dbg_ecode | output | 6 | Debug code |
| dbg_ret | output | PC_W | Debug return address |
| rf_plv | output | 2 | Refill saved level |
| rf_ie | output | 1 | Refill saved interrupt enable |
| rf_ret | output | PC_W-2 | Refill return field (PC >> 2) |
| err | output | 1 | Unsupported cause pulse |

## Verification
The bench builds the block with its defaults: a 32-bit PC and instruction word, a 3-bit spacing exponent and a 5-bit interrupt index. With these widths the spacing can be exercised at 0, at 1 and at 3. The interrupt vector offset (64 + index) shifted by the spacing stays well inside the PC width, so an exact target address can be checked. The 9-bit subcode leaves room for an out-of-range subcode on code 8 to be tried as a rejected cause.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    localparam int CODE_W = 6;
    localparam int SUB_W  = 9;

    localparam logic [CODE_W-1:0] EC_IRQ        = 6'd0;
    localparam logic [CODE_W-1:0] EC_LD_INV     = 6'd1;
    localparam logic [CODE_W-1:0] EC_ST_INV     = 6'd2;
    localparam logic [CODE_W-1:0] EC_IF_INV     = 6'd3;
    localparam logic [CODE_W-1:0] EC_MODIFY     = 6'd4;
    localparam logic [CODE_W-1:0] EC_NO_READ    = 6'd5;
    localparam logic [CODE_W-1:0] EC_NO_EXEC    = 6'd6;
    localparam logic [CODE_W-1:0] EC_PG_PRIV    = 6'd7;
    localparam logic [CODE_W-1:0] EC_ADDR       = 6'd8;
    localparam logic [CODE_W-1:0] EC_BOUND      = 6'd10;
    localparam logic [CODE_W-1:0] EC_SYSCALL    = 6'd11;
    localparam logic [CODE_W-1:0] EC_BREAK      = 6'd12;
    localparam logic [CODE_W-1:0] EC_UNDEF      = 6'd13;
    localparam logic [CODE_W-1:0] EC_INS_PRIV   = 6'd14;
    localparam logic [CODE_W-1:0] EC_FP_OFF     = 6'd15;
    localparam logic [CODE_W-1:0] EC_VEC_OFF    = 6'd16;
    localparam logic [CODE_W-1:0] EC_WVEC_OFF   = 6'd17;
    localparam logic [CODE_W-1:0] EC_FP_EXC     = 6'd18;
    localparam logic [CODE_W-1:0] EC_DBG_BP     = 6'd26;

    localparam logic [SUB_W-1:0]  SUB_FETCH     = 9'd0;
    localparam logic [SUB_W-1:0]  SUB_DATA      = 9'd1;
    localparam logic [CODE_W-1:0] DBG_BP_ECODE  = 6'hC;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DEBUG = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic ok;
        logic is_irq;
        logic is_dbp;
        logic set_badv;
        logic set_badi;
    } trap_class_t;
endpackage

// File: rtl/trap_cause_decode.sv
module trap_cause_decode
    import trap_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [SUB_W-1:0]  sub,
    output trap_class_t       cls
);
    always_comb begin
        cls = '0;
        unique case (code)
            EC_IRQ: begin
                cls.ok     = 1'b1;
                cls.is_irq = 1'b1;
            end
            EC_LD_INV, EC_ST_INV, EC_IF_INV, EC_MODIFY,
            EC_NO_READ, EC_NO_EXEC, EC_PG_PRIV, EC_BOUND: begin
                cls.ok = 1'b1;
            end
            EC_ADDR: begin
                cls.ok = (sub == SUB_FETCH) || (sub == SUB_DATA);
            end
            EC_SYSCALL, EC_BREAK, EC_UNDEF, EC_INS_PRIV,
            EC_FP_OFF, EC_VEC_OFF, EC_WVEC_OFF, EC_FP_EXC: begin
                cls.ok       = 1'b1;
                cls.set_badv = 1'b1;
            end
            EC_DBG_BP: begin
                cls.ok     = 1'b1;
                cls.is_dbp = 1'b1;
            end
            default: cls = '0;
        endcase
        // fetch-side causes have no trustworthy instruction word
        cls.set_badi = cls.ok && !cls.is_irq && !cls.is_dbp
                       && (code != EC_IF_INV)
                       && !((code == EC_ADDR) && (sub == SUB_FETCH));
    end
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
    import trap_seq_pkg::*;
#(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned VS_W     = 3,
    parameter int unsigned IRQ_W    = 5,
    parameter int unsigned EXT_BASE = 64,
    parameter int unsigned DBG_OFS  = 32'h480
) (
    input  logic [PC_W-1:0]   base,
    input  logic [PC_W-1:0]   refill_base,
    input  logic [VS_W-1:0]   vs,
    input  logic [IRQ_W-1:0]  irq_idx,
    input  logic [CODE_W-1:0] code,
    input  logic              is_irq,
    input  logic              to_debug,
    input  logic              to_refill,
    output logic [PC_W-1:0]   target
);
    localparam int unsigned SH_W = VS_W + 1;

    logic [SH_W-1:0] shamt;
    logic [PC_W-1:0] slot;
    logic [PC_W-1:0] offset;

    always_comb begin
        shamt  = {1'b0, vs} + SH_W'(2);
        slot   = is_irq ? (PC_W'(EXT_BASE) + PC_W'(irq_idx)) : PC_W'(code);
        offset = (vs == '0) ? '0 : (slot << shamt);
        if (to_debug) begin
            target = base + PC_W'(DBG_OFS);
        end else if (to_refill && !is_irq) begin
            target = refill_base;
        end else begin
            target = base + offset;
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned INSN_W   = 32,
    parameter int unsigned VS_W     = 3,
    parameter int unsigned IRQ_W    = 5,
    parameter int unsigned RESET_PC = 32'h1C00_0000,
    parameter int unsigned DBG_OFS  = 32'h480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic [5:0]        trap_code,
    input  logic [8:0]        trap_sub,
    input  logic [PC_W-1:0]   trap_pc,
    input  logic [INSN_W-1:0] trap_insn,
    input  logic              refill_active,
    input  logic [IRQ_W-1:0]  irq_index,
    input  logic              buserr_valid,
    input  logic              buserr_fetch,
    input  logic [PC_W-1:0]   entry_base,
    input  logic [PC_W-1:0]   refill_entry,
    input  logic [VS_W-1:0]   vec_spacing,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wr_plv,
    input  logic              mode_wr_ie,
    input  logic              mode_wr_da,
    input  logic              mode_wr_pg,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [1:0]        cur_plv,
    output logic              cur_ie,
    output logic              cur_da,
    output logic              cur_pg,
    output logic [1:0]        prv_plv,
    output logic              prv_ie,
    output logic [5:0]        est_code,
    output logic [8:0]        est_sub,
    output logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   bad_addr,
    output logic [INSN_W-1:0] bad_insn,
    output logic              dbg_mode,
    output logic              dbg_cause,
    output logic              dbg_int,
    output logic [5:0]        dbg_ecode,
    output logic [PC_W-1:0]   dbg_ret,
    output logic [1:0]        rf_plv,
    output logic              rf_ie,
    output logic [PC_W-3:0]   rf_ret,
    output logic              err
);
    seq_state_t        state, state_nxt;
    trap_class_t       cls;
    logic              take;
    logic [CODE_W-1:0] eff_code;
    logic [SUB_W-1:0]  eff_sub;
    logic              dbg_path;
    logic              accept;
    logic [PC_W-1:0]   target;

    // trap strobe outranks a bus error in the same cycle
    always_comb begin
        take     = trap_valid || buserr_valid;
        eff_code = trap_valid ? trap_code : EC_ADDR;
        eff_sub  = trap_valid ? trap_sub : (buserr_fetch ? SUB_FETCH : SUB_DATA);
    end

    trap_cause_decode u_decode (
        .code (eff_code),
        .sub  (eff_sub),
        .cls  (cls)
    );

    always_comb begin
        accept   = take && cls.ok;
        dbg_path = cls.is_dbp || (cls.is_irq && (state == ST_DEBUG));
    end

    trap_vector_calc #(
        .PC_W    (PC_W),
        .VS_W    (VS_W),
        .IRQ_W   (IRQ_W),
        .EXT_BASE(64),
        .DBG_OFS (DBG_OFS)
    ) u_vector (
        .base       (entry_base),
        .refill_base(refill_entry),
        .vs         (vec_spacing),
        .irq_idx    (irq_index),
        .code       (eff_code),
        .is_irq     (cls.is_irq),
        .to_debug   (dbg_path),
        .to_refill  (refill_active),
        .target     (target)
    );

    // next-state logic: ENTER_DEBUG and HOLD_DEBUG
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (accept && dbg_path) state_nxt = ST_DEBUG;
            ST_DEBUG: state_nxt = ST_DEBUG;
            default:  state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    assign dbg_mode = (state == ST_DEBUG);

    // architectural register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= PC_W'(RESET_PC);
            cur_plv        <= 2'd0;
            cur_ie         <= 1'b0;
            cur_da         <= 1'b1;
            cur_pg         <= 1'b0;
            prv_plv        <= 2'd0;
            prv_ie         <= 1'b0;
            est_code       <= '0;
            est_sub        <= '0;
            ret_addr       <= '0;
            bad_addr       <= '0;
            bad_insn       <= '0;
            dbg_cause      <= 1'b0;
            dbg_int        <= 1'b0;
            dbg_ecode      <= '0;
            dbg_ret        <= '0;
            rf_plv         <= 2'd0;
            rf_ie          <= 1'b0;
            rf_ret         <= '0;
            err            <= 1'b0;
        end else begin
            redirect_valid <= accept;
            err            <= take && !cls.ok;
            if (accept) redirect_pc <= target;

            if (accept && dbg_path) begin
                dbg_ret <= trap_pc;
                if (cls.is_dbp) begin
                    dbg_cause <= 1'b1;
                    dbg_ecode <= DBG_BP_ECODE;
                end else begin
                    dbg_int <= 1'b1;
                end
            end else if (accept) begin
                if (cls.set_badv) bad_addr <= trap_pc;
                if (cls.set_badi) bad_insn <= trap_insn;
                if (refill_active) begin
                    rf_plv <= cur_plv;
                    rf_ie  <= cur_ie;
                    rf_ret <= trap_pc[PC_W-1:2];
                    cur_da <= 1'b1;
                    cur_pg <= 1'b0;
                end else begin
                    est_code <= eff_code;
                    est_sub  <= eff_sub;
                    prv_plv  <= cur_plv;
                    prv_ie   <= cur_ie;
                    ret_addr <= trap_pc;
                end
                cur_plv <= 2'd0;
                cur_ie  <= 1'b0;
            end else if (!take && mode_wr) begin
                cur_plv <= mode_wr_plv;
                cur_ie  <= mode_wr_ie;
                cur_da  <= mode_wr_da;
                cur_pg  <= mode_wr_pg;
            end
        end
    end

    a_r3_entry_drops_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls.ok && !dbg_path) |=> (cur_plv == 2'd0 && !cur_ie));

    a_r9_debug_target: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls.ok && dbg_path) |=>
            (dbg_mode && redirect_pc == $past(entry_base) + PC_W'(DBG_OFS)));

    a_r12_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cls.ok) |=>
            (err && !redirect_valid && $stable(ret_addr) && $stable(bad_addr)
             && $stable(est_code) && $stable(dbg_ret)));

    a_r8_refill_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls.ok && !dbg_path && refill_active) |=>
            (cur_da && !cur_pg && rf_ret == $past(trap_pc[PC_W-1:2])));

    a_r2_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls.ok && !dbg_path && !refill_active) |=>
            (redirect_valid && ret_addr == $past(trap_pc)));

    a_r10_debug_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |=> dbg_mode);
endmodule

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;
    localparam int PC_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [5:0]  trap_code = '0;
    logic [8:0]  trap_sub = '0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_insn = '0;
    logic        refill_active = 1'b0;
    logic [4:0]  irq_index = '0;
    logic        buserr_valid = 1'b0;
    logic        buserr_fetch = 1'b0;
    logic [31:0] entry_base = 32'h8000_0000;
    logic [31:0] refill_entry = 32'h9000_0000;
    logic [2:0]  vec_spacing = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wr_plv = '0;
    logic        mode_wr_ie = 1'b0;
    logic        mode_wr_da = 1'b0;
    logic        mode_wr_pg = 1'b0;

    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  cur_plv, prv_plv, rf_plv;
    logic        cur_ie, cur_da, cur_pg, prv_ie, rf_ie;
    logic [5:0]  est_code, dbg_ecode;
    logic [8:0]  est_sub;
    logic [31:0] ret_addr, bad_addr, bad_insn, dbg_ret;
    logic        dbg_mode, dbg_cause, dbg_int, err;
    logic [29:0] rf_ret;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trap_entry_seq i_trap_entry_seq (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_code(trap_code),
        .trap_sub(trap_sub), .trap_pc(trap_pc), .trap_insn(trap_insn),
        .refill_active(refill_active), .irq_index(irq_index),
        .buserr_valid(buserr_valid), .buserr_fetch(buserr_fetch),
        .entry_base(entry_base), .refill_entry(refill_entry), .vec_spacing(vec_spacing),
        .mode_wr(mode_wr), .mode_wr_plv(mode_wr_plv), .mode_wr_ie(mode_wr_ie),
        .mode_wr_da(mode_wr_da), .mode_wr_pg(mode_wr_pg),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .cur_plv(cur_plv), .cur_ie(cur_ie), .cur_da(cur_da), .cur_pg(cur_pg),
        .prv_plv(prv_plv), .prv_ie(prv_ie), .est_code(est_code), .est_sub(est_sub),
        .ret_addr(ret_addr), .bad_addr(bad_addr), .bad_insn(bad_insn),
        .dbg_mode(dbg_mode), .dbg_cause(dbg_cause), .dbg_int(dbg_int),
        .dbg_ecode(dbg_ecode), .dbg_ret(dbg_ret), .rf_plv(rf_plv), .rf_ie(rf_ie),
        .rf_ret(rf_ret), .err(err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_mode(input logic [1:0] plv, input logic ie,
                            input logic da, input logic pg);
        @(negedge clk);
        mode_wr = 1'b1; mode_wr_plv = plv; mode_wr_ie = ie;
        mode_wr_da = da; mode_wr_pg = pg;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // strobe one trap; on return outputs reflect the edge that took it
    task automatic fire(input logic [5:0] code, input logic [8:0] sub,
                        input logic [31:0] pc, input logic [31:0] insn);
        @(negedge clk);
        trap_valid = 1'b1; trap_code = code; trap_sub = sub;
        trap_pc = pc; trap_insn = insn;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "plv", 32'(cur_plv), 0);
        check("R1", "ie", 32'(cur_ie), 0);
        check("R1", "da", 32'(cur_da), 1);
        check("R1", "pg", 32'(cur_pg), 0);
        check("R1", "dbg_mode", 32'(dbg_mode), 0);
        check("R1", "est_code", 32'(est_code), 0);
        check("R1", "redirect_pc", redirect_pc, 32'h1C00_0000);
        check("R1", "redirect_valid", 32'(redirect_valid), 0);
        check("R1", "err", 32'(err), 0);
    endtask

    task automatic t_mode_write();
        set_mode(2'd3, 1'b1, 1'b0, 1'b1);
        check("R13", "plv", 32'(cur_plv), 3);
        check("R13", "ie", 32'(cur_ie), 1);
        check("R13", "da", 32'(cur_da), 0);
        check("R13", "pg", 32'(cur_pg), 1);
    endtask

    task automatic t_syscall();
        vec_spacing = 3'd0;
        fire(6'd11, 9'd0, 32'h0000_1000, 32'hDEAD_BEEF);
        check("R2", "est_code", 32'(est_code), 11);
        check("R2", "est_sub", 32'(est_sub), 0);
        check("R2", "prv_plv", 32'(prv_plv), 3);
        check("R2", "prv_ie", 32'(prv_ie), 1);
        check("R2", "ret_addr", ret_addr, 32'h1000);
        check("R2", "redirect_valid", 32'(redirect_valid), 1);
        check("R3", "plv", 32'(cur_plv), 0);
        check("R3", "ie", 32'(cur_ie), 0);
        check("R4", "target vs0", redirect_pc, 32'h8000_0000);
        check("R6", "bad_addr", bad_addr, 32'h1000);
        check("R7", "bad_insn", bad_insn, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R2", "redirect pulse ends", 32'(redirect_valid), 0);
    endtask

    task automatic t_load_invalid();
        vec_spacing = 3'd3;
        fire(6'd1, 9'd0, 32'h0000_2000, 32'h0000_1111);
        check("R4", "target vs3", redirect_pc, 32'h8000_0020);
        check("R6", "bad_addr kept", bad_addr, 32'h1000);
        check("R7", "bad_insn", bad_insn, 32'h1111);
    endtask

    task automatic t_interrupt();
        vec_spacing = 3'd1;
        irq_index = 5'd5;
        fire(6'd0, 9'd0, 32'h0000_2400, 32'h0000_2222);
        check("R5", "irq target", redirect_pc, 32'h8000_0228);
        check("R5", "est_code", 32'(est_code), 0);
        check("R7", "irq keeps bad_insn", bad_insn, 32'h1111);
        check("R10", "no debug int outside debug", 32'(dbg_int), 0);
        fire(6'd3, 9'd0, 32'h0000_2800, 32'h0000_3333);
        check("R7", "fetch invalid keeps bad_insn", bad_insn, 32'h1111);
    endtask

    task automatic t_bus_errors();
        @(negedge clk);
        buserr_valid = 1'b1; buserr_fetch = 1'b1;
        trap_pc = 32'h0000_4000; trap_insn = 32'h0000_4444;
        @(negedge clk);
        buserr_valid = 1'b0;
        check("R11", "fetch code", 32'(est_code), 8);
        check("R11", "fetch sub", 32'(est_sub), 0);
        check("R7", "fetch addr error keeps bad_insn", bad_insn, 32'h1111);
        @(negedge clk);
        buserr_valid = 1'b1; buserr_fetch = 1'b0;
        trap_pc = 32'h0000_4100; trap_insn = 32'h0000_5555;
        @(negedge clk);
        buserr_valid = 1'b0;
        check("R11", "data code", 32'(est_code), 8);
        check("R11", "data sub", 32'(est_sub), 1);
        check("R7", "data addr error bad_insn", bad_insn, 32'h5555);
    endtask

    task automatic t_refill();
        set_mode(2'd2, 1'b1, 1'b0, 1'b1);
        refill_active = 1'b1;
        fire(6'd1, 9'd0, 32'h0000_3004, 32'h0000_6666);
        refill_active = 1'b0;
        check("R8", "rf_plv", 32'(rf_plv), 2);
        check("R8", "rf_ie", 32'(rf_ie), 1);
        check("R8", "rf_ret", 32'(rf_ret), 32'hC01);
        check("R8", "da", 32'(cur_da), 1);
        check("R8", "pg", 32'(cur_pg), 0);
        check("R8", "target", redirect_pc, 32'h9000_0000);
        check("R8", "est kept", 32'(est_sub), 1);
        check("R8", "ret kept", ret_addr, 32'h4100);
    endtask

    task automatic t_reject();
        logic [31:0] old_pc;
        old_pc = redirect_pc;
        fire(6'd9, 9'd0, 32'h0000_7000, 32'h0000_7777);
        check("R12", "err", 32'(err), 1);
        check("R12", "no redirect", 32'(redirect_valid), 0);
        check("R12", "redirect_pc kept", redirect_pc, old_pc);
        check("R12", "ret kept", ret_addr, 32'h4100);
        check("R12", "bad_insn kept", bad_insn, 32'h6666);
        fire(6'd8, 9'd5, 32'h0000_7100, 32'h0000_7878);
        check("R12", "code8 sub5 err", 32'(err), 1);
        check("R12", "code8 sub5 est kept", 32'(est_code), 8);
        @(negedge clk);
        check("R12", "err pulse ends", 32'(err), 0);
    endtask

    task automatic t_trap_beats_write();
        @(negedge clk);
        mode_wr = 1'b1; mode_wr_plv = 2'd3; mode_wr_ie = 1'b1;
        mode_wr_da = 1'b0; mode_wr_pg = 1'b1;
        trap_valid = 1'b1; trap_code = 6'd12; trap_sub = '0;
        trap_pc = 32'h0000_8000; trap_insn = 32'h0000_8888;
        @(negedge clk);
        trap_valid = 1'b0; mode_wr = 1'b0;
        check("R13", "trap wins plv", 32'(cur_plv), 0);
        check("R6", "break bad_addr", bad_addr, 32'h8000);
    endtask

    task automatic t_debug();
        set_mode(2'd1, 1'b1, 1'b0, 1'b1);
        fire(6'd26, 9'd0, 32'h0000_5000, 32'h0000_9999);
        check("R9", "dbg_cause", 32'(dbg_cause), 1);
        check("R9", "dbg_ecode", 32'(dbg_ecode), 32'hC);
        check("R9", "dbg_ret", dbg_ret, 32'h5000);
        check("R9", "dbg_mode", 32'(dbg_mode), 1);
        check("R9", "target", redirect_pc, 32'h8000_0480);
        check("R9", "plv kept", 32'(cur_plv), 1);
        check("R9", "ret kept", ret_addr, 32'h8000);
        fire(6'd0, 9'd0, 32'h0000_6000, 32'h0000_AAAA);
        check("R10", "dbg_int", 32'(dbg_int), 1);
        check("R10", "dbg_ret", dbg_ret, 32'h6000);
        check("R10", "target", redirect_pc, 32'h8000_0480);
        check("R10", "est kept", 32'(est_code), 12);
    endtask

    bit done = 1'b0;

    initial begin
        do_reset();
        t_reset();
        t_mode_write();
        t_syscall();
        t_load_invalid();
        t_interrupt();
        t_bus_errors();
        t_refill();
        t_reject();
        t_trap_beats_write();
        t_debug();
        do_reset();
        t_reset();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule